// File: doc/BRIEF.md
# Paired Register Bank Access Controller

This block is the register side of a 16-pin byte-oriented port expander. A serial slave front end, which is not part of this block, decodes the wire protocol and passes it single-cycle events. These events are start, stop, address match with a read/write flag, received byte, and request for a byte to transmit. The controller holds eight byte registers in four pairs. The first byte of a write transfer becomes the register pointer. Each following byte goes to the register under the pointer.

After every data byte, or every byte read, the pointer moves to the other register of its pair. It never advances to the next pair. A long burst therefore keeps updating both halves of one 16-bit register. Reads start at the last pointer written and alternate in the same way. Bytes read from the input pair return the live pin levels XOR the polarity mask. The output and configuration registers drive the pin values and the per-pin drive enables directly.

Top module: `paired_reg_bank`

## Requirements
- R1: After `rst_n` is released, `pin_out` is 16'hFFFF, `pin_oe` is 0, both polarity registers read 0, `rd_data` is 0 and the pointer is 0.
- R2: In a write transfer, the first byte after the address match loads the pointer from bits [2:0] of the byte. Bits [7:3] are ignored. Register indices are: 0/1 input low/high, 2/3 output low/high, 4/5 polarity low/high, 6/7 configuration low/high.
- R3: Each later byte of a write transfer is stored in the register under the pointer. A change to an output register appears on `pin_out` one clock after the byte event. Even registers hold pin bits [7:0] and odd registers hold pin bits [15:8].
- R4: After every data byte the pointer flips bit 0 only, staying inside its pair. This holds for any number of bytes, so a write that starts at register 3 continues at 2, then 3, and so on.
- R5: Data bytes aimed at register 0 or 1 leave every register unchanged, but the pointer still flips.
- R6: In a read transfer, each `ev_rd_req` puts the addressed register on `rd_data` one clock later and then flips pointer bit 0. Register 0 or 1 returns the corresponding byte of `pin_in` XOR the matching polarity byte.
- R7: A stop or a start ends data steering, and byte events are then ignored until the next address match. The pointer is kept, so a following read starts where the write left it.
- R8: Each bit of `pin_oe` is the inverse of the corresponding configuration bit (1 = input, not driven).
- R9: `ev_rd_req` outside a read transfer leaves `rd_data` and the pointer unchanged. `ev_byte_vld` during a read transfer or when idle changes nothing.
- R10: Asserting `rst_n` low in the middle of a transfer restores the R1 state and the idle protocol state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| ev_addr | input | 1 | Own address matched |
| ev_rnw | input | 1 | Direction with ev_addr, 1 = read |
| ev_byte_vld | input | 1 | Received byte strobe |
| ev_byte | input | 8 | Received byte |
| ev_rd_req | input | 1 | Front end needs the next byte to send |
| rd_data | output | 8 | Byte to transmit, valid one clock after ev_rd_req |
| pin_in | input | 16 | Sampled pin levels |
| pin_out | output | 16 | Output register values |
| pin_oe | output | 16 | Per-pin drive enable |

## Verification
A wrong pointer shows up on the very next data byte. Either the wrong half of `pin_out`/`pin_oe` changes one clock after the byte, or a read one clock after its request returns a byte from the wrong register. A wrong protocol state, such as steering that is still open after a stop, shows as a pin change after a byte that should have been ignored. A polarity fault appears only when the input pair is read, so the random mix reads registers 0 and 1 after random polarity writes, with `pin_in` changing between transfers.

// File: rtl/paired_reg_bank.sv
module paired_reg_bank #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_start,
  input  logic            ev_stop,
  input  logic            ev_addr,
  input  logic            ev_rnw,
  input  logic            ev_byte_vld,
  input  logic [7:0]      ev_byte,
  input  logic            ev_rd_req,
  output logic [7:0]      rd_data,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe
);
  localparam int HALF = PINS / 2;

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_WR, S_RD} st_t;

  st_t             st;
  logic [2:0]      ptr;
  logic [PINS-1:0] out_q, pol_q, cfg_q;

  wire frame_evt = ev_start | ev_stop;
  wire byte_evt  = ev_byte_vld & ~frame_evt & ~ev_addr;
  wire rd_evt    = ev_rd_req & ~ev_byte_vld & ~frame_evt & ~ev_addr & (st == S_RD);
  wire wr_evt    = byte_evt & (st == S_WR);
  wire cmd_evt   = byte_evt & (st == S_CMD);

  function automatic logic [7:0] half_sel(input logic [PINS-1:0] v, input logic hi);
    return hi ? v[PINS-1 -: HALF] : v[HALF-1:0];
  endfunction

  function automatic logic [PINS-1:0] half_put(input logic [PINS-1:0] v, input logic hi,
                                               input logic [7:0] b);
    logic [PINS-1:0] r;
    r = v;
    if (hi) r[PINS-1 -: HALF] = b;
    else    r[HALF-1:0] = b;
    return r;
  endfunction

  logic [7:0] rd_mux;
  always_comb begin
    unique case (ptr[2:1])
      2'd0:    rd_mux = half_sel(pin_in ^ pol_q, ptr[0]);
      2'd1:    rd_mux = half_sel(out_q, ptr[0]);
      2'd2:    rd_mux = half_sel(pol_q, ptr[0]);
      default: rd_mux = half_sel(cfg_q, ptr[0]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ptr     <= '0;
      out_q   <= '1;
      pol_q   <= '0;
      cfg_q   <= '1;
      rd_data <= '0;
    end else if (frame_evt) begin
      st <= S_IDLE;
    end else if (ev_addr) begin
      st <= ev_rnw ? S_RD : S_CMD;
    end else if (cmd_evt) begin
      ptr <= ev_byte[2:0];
      st  <= S_WR;
    end else if (wr_evt) begin
      unique case (ptr[2:1])
        2'd1:    out_q <= half_put(out_q, ptr[0], ev_byte);
        2'd2:    pol_q <= half_put(pol_q, ptr[0], ev_byte);
        2'd3:    cfg_q <= half_put(cfg_q, ptr[0], ev_byte);
        default: ;
      endcase
      ptr[0] <= ~ptr[0];
    end else if (rd_evt) begin
      rd_data <= rd_mux;
      ptr[0]  <= ~ptr[0];
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = ~cfg_q;

  p_cmd_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_evt |=> ptr == $past(ev_byte[2:0]));

  p_pair_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt || rd_evt) |=> (ptr[2:1] == $past(ptr[2:1])) && (ptr[0] != $past(ptr[0])));

  p_input_pair_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && ptr[2:1] == 2'd0) |=> $stable(pin_out) && $stable(pin_oe) && $stable(pol_q));

  p_closed_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && (st == S_IDLE || st == S_RD)) |=> $stable(pin_out) && $stable(pin_oe) && $stable(ptr));

  p_frame_keeps_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> $stable(ptr) && st == S_IDLE);

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(rd_data));

  p_pins_only_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> $stable(pin_out) && $stable(pin_oe));
endmodule

// File: tb/tb_paired_reg_bank.sv
module tb_paired_reg_bank;
  logic clk = 0, rst_n = 0;
  logic ev_start = 0, ev_stop = 0, ev_addr = 0, ev_rnw = 0, ev_byte_vld = 0, ev_rd_req = 0;
  logic [7:0] ev_byte = 0;
  logic [7:0] rd_data;
  logic [15:0] pin_in = 16'h0000, pin_out, pin_oe;

  paired_reg_bank dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] m_reg [8];
  logic [2:0] m_ptr;
  int m_st; // 0 idle,1 cmd,2 wr,3 rd

  function automatic logic [7:0] exp_rd(input logic [2:0] p);
    if (p == 3'd0) return pin_in[7:0] ^ m_reg[4];
    if (p == 3'd1) return pin_in[15:8] ^ m_reg[5];
    return m_reg[p];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_pins(input string req);
    chk(req, pin_out, {m_reg[3], m_reg[2]});
    chk(req, pin_oe, ~{m_reg[7], m_reg[6]});
  endtask

  task automatic model_reset();
    m_reg[0] = 0; m_reg[1] = 0; m_reg[2] = 8'hFF; m_reg[3] = 8'hFF;
    m_reg[4] = 0; m_reg[5] = 0; m_reg[6] = 8'hFF; m_reg[7] = 8'hFF;
    m_ptr = 0; m_st = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    model_reset();
  endtask

  task automatic frame(input bit is_stop);
    @(negedge clk); if (is_stop) ev_stop = 1; else ev_start = 1;
    @(negedge clk); ev_stop = 0; ev_start = 0;
    m_st = 0;
  endtask

  task automatic addr(input bit rnw);
    @(negedge clk); ev_addr = 1; ev_rnw = rnw;
    @(negedge clk); ev_addr = 0;
    m_st = rnw ? 3 : 1;
  endtask

  task automatic send(input logic [7:0] b, input string req);
    @(negedge clk); ev_byte_vld = 1; ev_byte = b;
    @(negedge clk); ev_byte_vld = 0;
    if (m_st == 1) begin m_ptr = b[2:0]; m_st = 2; end
    else if (m_st == 2) begin
      if (m_ptr >= 2) m_reg[m_ptr] = b;
      m_ptr[0] = ~m_ptr[0];
    end
    chk_pins(req);
  endtask

  task automatic fetch(input string req);
    logic [7:0] e;
    logic [7:0] prev;
    prev = rd_data;
    @(negedge clk); ev_rd_req = 1;
    e = (m_st == 3) ? exp_rd(m_ptr) : prev;
    @(negedge clk); ev_rd_req = 0;
    if (m_st == 3) m_ptr[0] = ~m_ptr[0];
    chk(req, {8'h00, rd_data}, {8'h00, e});
  endtask

  initial begin
    #(100000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    do_reset();
    // R1 reset state
    chk("R1", pin_out, 16'hFFFF);
    chk("R1", pin_oe, 16'h0000);
    chk("R1", {8'h00, rd_data}, 16'h0000);
    frame(0); addr(1); fetch("R1"); fetch("R1"); fetch("R1"); frame(1);
    // R2 upper command bits ignored, R3/R4 start at 3 then 2
    frame(0); addr(0); send(8'hFB, "R2");
    send(8'hA5, "R3"); send(8'h3C, "R4"); send(8'h11, "R4"); send(8'h22, "R4");
    frame(1);
    // R7 byte after stop ignored, pointer kept for read
    send(8'h99, "R7");
    frame(0); addr(1); fetch("R7"); fetch("R6"); frame(1);
    // R5 writes to input pair discarded
    frame(0); addr(0); send(8'h00, "R2"); send(8'h55, "R5"); send(8'hAA, "R5"); send(8'h12, "R5");
    frame(0); addr(1); fetch("R5");
    // R9 byte during read ignored
    send(8'h77, "R9"); frame(1);
    // R9 rd_req outside read
    fetch("R9");
    // R8 config write
    frame(0); addr(0); send(8'h06, "R2"); send(8'h0F, "R8"); send(8'hF0, "R8"); frame(1);
    // R6 polarity + input read
    pin_in = 16'hC3A5;
    frame(0); addr(0); send(8'h04, "R2"); send(8'hFF, "R6"); send(8'h0F, "R6");
    frame(0); addr(1); fetch("R6"); fetch("R6"); fetch("R6"); frame(1);
    // random mix
    for (int t = 0; t < 400; t++) begin
      int k;
      pin_in = 16'($urandom);
      k = $urandom_range(0, 2);
      frame(0);
      if (k == 0) begin
        addr(1);
        for (int i = 0; i < $urandom_range(1, 5); i++) fetch("R6");
      end else begin
        addr(0);
        send(8'($urandom), "R2");
        for (int i = 0; i < $urandom_range(0, 6); i++) send(8'($urandom), "R4");
      end
      if ($urandom_range(0, 3) == 0) send(8'($urandom), "R7");
      if ($urandom_range(0, 1) == 0) frame(1);
    end
    // R10 reset mid transfer
    frame(0); addr(0); send(8'h02, "R2"); send(8'h01, "R3");
    do_reset();
    chk("R10", pin_out, 16'hFFFF);
    chk("R10", pin_oe, 16'h0000);
    send(8'h44, "R10");
    frame(0); addr(1); fetch("R10"); frame(1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule